// File: doc/BRIEF.md
# Processor Interrupt Entry Controller

This block decides when an 8-bit processor leaves its instruction stream to service an interrupt, and it steps through the bus requests that the entry needs. It watches a non-maskable request pin, which is latched on its falling edge, and a level-sensitive maskable request pin. It holds the two interrupt-enable flip-flops (the live enable and its saved copy) and the maskable response mode. It takes an end-of-instruction pulse and a halted level from the core. A pending request is evaluated only at such an instruction boundary.

Once a request is accepted, the block steps through a short sequence. It asks the core to push the program counter, to run an acknowledge cycle (M1 with IORQ) or to read a vector word. It then reports the new program counter, or it passes the acknowledge bytes to the core as injected opcodes. The core does the stack write, the bus cycles and the execution. The block only asks for them and waits for each done strobe.

Top module: `intc_top`

## Requirements
- R1: While reset is held, and after it is released, iff1 and iff2 read 0, intMode reads 0, pcTarget reads 0, and busy, ackReq, pushReq, vecReadReq, pcLoad and injValid are all 0.
- R2: A 1-to-0 transition on nmiN is remembered until service starts, even after nmiN returns high. With no boundary (instrEnd or halted high at a clock edge) the block stays idle. A boundary signalled by halted alone starts service on that edge.
- R3: Non-maskable entry copies iff1 into iff2 and clears iff1 on the boundary edge. It then raises pushReq until pushDone, and then pulses pcLoad for one cycle with pcTarget = NMI_VEC (default 0x0066).
- R4: cmdRetn in idle copies iff2 into iff1 on the next edge.
- R5: A low intN at a boundary is accepted only while iff1 is 1. Acceptance clears both iff1 and iff2 on that edge and sets busy. With iff1 at 0 the block stays idle.
- R6: When both a pending non-maskable request and an acceptable maskable request meet at one boundary, the non-maskable entry is taken: pushReq rises and ackReq does not.
- R7: cmdEi sets iff1 and iff2. A low intN is not accepted at the first boundary after cmdEi, or at a boundary in the same cycle as cmdEi. It is accepted at the boundary after that.
- R8: Mode 0 entry raises ackReq and pcHold and never raises pushReq or pcLoad. Each cycle with ackDone high drives injValid high with injByte = ackData in that same cycle. The ackDone that comes with ackLast ends the service.
- R9: Mode 1 entry raises ackReq until ackDone, and ackData has no effect. It then raises pushReq until pushDone, and then pulses pcLoad with pcTarget = IM1_VEC (default 0x0038).
- R10: Mode 2 entry raises pushReq before ackReq. After ackDone it raises vecReadReq with vecAddr = {iReg, ackData captured at ackDone}. After vecDone it pulses pcLoad with pcTarget = the vecWord presented with vecDone.
- R11: cmdSetMode in idle loads intMode from modeSel when modeSel is 0, 1 or 2, and a modeSel of 3 leaves intMode unchanged. cmdDi in idle clears iff1 and iff2.
- R12: At most one of ackReq, pushReq, vecReadReq and pcLoad is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| nmiN | input | 1 | Non-maskable request, falling-edge sensitive |
| intN | input | 1 | Maskable request, active low level |
| instrEnd | input | 1 | One-cycle end-of-instruction pulse |
| halted | input | 1 | Core is halted; every cycle is a boundary |
| cmdEi | input | 1 | Enable-interrupts command |
| cmdDi | input | 1 | Disable-interrupts command |
| cmdRetn | input | 1 | Return-from-non-maskable command |
| cmdSetMode | input | 1 | Load the response mode from modeSel |
| modeSel | input | 2 | Mode for cmdSetMode |
| iReg | input | DATA_W | Vector-table page register |
| ackData | input | DATA_W | Byte captured during acknowledge |
| ackDone | input | 1 | Acknowledge cycle complete, ackData valid |
| ackLast | input | 1 | With ackDone in mode 0: final injected byte |
| pushDone | input | 1 | Program-counter push complete |
| vecWord | input | 2*DATA_W | Word read from the vector table |
| vecDone | input | 1 | Vector read complete, vecWord valid |
| iff1 | output | 1 | Live interrupt enable |
| iff2 | output | 1 | Saved interrupt enable |
| intMode | output | 2 | Current maskable response mode |
| busy | output | 1 | An entry sequence is running |
| ackReq | output | 1 | Request an M1+IORQ acknowledge cycle |
| pushReq | output | 1 | Request a push of the program counter |
| vecReadReq | output | 1 | Request a read of the vector word |
| vecAddr | output | 2*DATA_W | Address of the vector word |
| pcLoad | output | 1 | One-cycle strobe: load pcTarget into the PC |
| pcTarget | output | 2*DATA_W | New program counter |
| pcHold | output | 1 | Mode 0 service: do not advance the PC |
| injValid | output | 1 | Injected opcode byte valid |
| injByte | output | DATA_W | Injected opcode byte |

## Verification
The bench builds the block with the defaults: DATA_W = 8, so addresses are 16 bits, NMI_VEC = 0x0066 and IM1_VEC = 0x0038. These give the fixed targets that the checks expect. The vector address then spans the whole 64 KiB space, so the page-0xFF / offset-0x00 corner and a mid-page pointer can both be reached with a single pointer byte. A table walks each response mode through its full handshake. Directed tests then cover the enable shadow, edge latching without a boundary, the halted boundary, the priority clash and the enable save and restore.

// File: rtl/intc_pkg.sv
package intc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH,
    ST_ACK,
    ST_VEC,
    ST_LOAD
  } svcState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic takeNmi;
    logic takeInt;
    logic cmdOk;
    logic latchAck;
    logic latchVec;
  } dpStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic       nmiPend;
    logic       intOk;
    logic [1:0] mode;
  } dpStatus_t;

endpackage

// File: rtl/intc_dpath.sv
module intc_dpath
  import intc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2 * DATA_W,
  parameter logic [ADDR_W-1:0] NMI_VEC = 'h0066,
  parameter logic [ADDR_W-1:0] IM1_VEC = 'h0038
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              nmiN,
  input  logic              intN,
  input  logic              boundary,
  input  logic              cmdEi,
  input  logic              cmdDi,
  input  logic              cmdRetn,
  input  logic              cmdSetMode,
  input  logic [1:0]        modeSel,
  input  logic [DATA_W-1:0] iReg,
  input  logic [DATA_W-1:0] ackData,
  input  logic [ADDR_W-1:0] vecWord,
  input  dpStrobe_t         strb,
  output dpStatus_t         stat,
  output logic              iff1,
  output logic              iff2,
  output logic [1:0]        intMode,
  output logic [ADDR_W-1:0] vecAddr,
  output logic [ADDR_W-1:0] tgt
);

  logic              nmiPrev;
  logic              nmiPend;
  logic              eiShadow;
  logic [DATA_W-1:0] ackQ;

  // falling-edge latch, cleared only when entry begins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiPrev <= 1'b1;
      nmiPend <= 1'b0;
    end else begin
      nmiPrev <= nmiN;
      if (nmiPrev && !nmiN)  nmiPend <= 1'b1;
      else if (strb.takeNmi) nmiPend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      iff1     <= 1'b0;
      iff2     <= 1'b0;
      intMode  <= 2'd0;
      eiShadow <= 1'b0;
    end else begin
      if (strb.takeNmi) begin
        iff2 <= iff1;
        iff1 <= 1'b0;
      end else if (strb.takeInt) begin
        iff1 <= 1'b0;
        iff2 <= 1'b0;
      end else if (strb.cmdOk) begin
        if (cmdEi) begin
          iff1 <= 1'b1;
          iff2 <= 1'b1;
        end else if (cmdDi) begin
          iff1 <= 1'b0;
          iff2 <= 1'b0;
        end else if (cmdRetn) begin
          iff1 <= iff2;
        end
        if (cmdSetMode && modeSel != 2'd3) intMode <= modeSel;
      end
      if (strb.cmdOk && cmdEi) eiShadow <= 1'b1;
      else if (boundary)       eiShadow <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackQ <= '0;
      tgt  <= '0;
    end else begin
      if (strb.latchAck) ackQ <= ackData;
      if (strb.takeNmi)                           tgt <= NMI_VEC;
      else if (strb.takeInt && intMode == 2'd1)   tgt <= IM1_VEC;
      else if (strb.latchVec)                     tgt <= vecWord;
    end
  end

  assign vecAddr      = {iReg, ackQ};
  assign stat.nmiPend = nmiPend;
  assign stat.intOk   = !intN && iff1 && !eiShadow && !cmdEi;
  assign stat.mode    = intMode;

endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      boundary,
  input  dpStatus_t stat,
  input  logic      ackDone,
  input  logic      ackLast,
  input  logic      pushDone,
  input  logic      vecDone,
  output dpStrobe_t strb,
  output logic      busy,
  output logic      ackReq,
  output logic      pushReq,
  output logic      vecReadReq,
  output logic      pcLoad,
  output logic      pcHold,
  output logic      injValid,
  output logic      svcNmi
);

  svcState_t  st, stNext;
  logic [1:0] svcMode;
  logic       idle;

  assign idle          = (st == ST_IDLE);
  assign strb.cmdOk    = idle;
  assign strb.takeNmi  = idle && boundary && stat.nmiPend;
  assign strb.takeInt  = idle && boundary && !stat.nmiPend && stat.intOk;
  assign strb.latchAck = (st == ST_ACK) && ackDone;
  assign strb.latchVec = (st == ST_VEC) && vecDone;

  always_comb begin
    stNext = st;
    unique case (st)
      ST_IDLE: begin
        if (strb.takeNmi)      stNext = ST_PUSH;
        else if (strb.takeInt) stNext = (stat.mode == 2'd2) ? ST_PUSH : ST_ACK;
      end
      ST_PUSH: if (pushDone) stNext = (svcNmi || svcMode == 2'd1) ? ST_LOAD : ST_ACK;
      ST_ACK: begin
        if (ackDone) begin
          if (svcMode == 2'd0)      stNext = ackLast ? ST_IDLE : ST_ACK;
          else if (svcMode == 2'd1) stNext = ST_PUSH;
          else                      stNext = ST_VEC;
        end
      end
      ST_VEC:  if (vecDone) stNext = ST_LOAD;
      ST_LOAD: stNext = ST_IDLE;
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= ST_IDLE;
      svcNmi  <= 1'b0;
      svcMode <= 2'd0;
    end else begin
      st <= stNext;
      if (strb.takeNmi) begin
        svcNmi <= 1'b1;
      end else if (strb.takeInt) begin
        svcNmi  <= 1'b0;
        svcMode <= stat.mode;
      end
    end
  end

  assign busy       = !idle;
  assign ackReq     = (st == ST_ACK);
  assign pushReq    = (st == ST_PUSH);
  assign vecReadReq = (st == ST_VEC);
  assign pcLoad     = (st == ST_LOAD);
  assign pcHold     = !idle && !svcNmi && svcMode == 2'd0;
  assign injValid   = (st == ST_ACK) && !svcNmi && svcMode == 2'd0 && ackDone;

endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W,
  parameter logic [ADDR_W-1:0] NMI_VEC = 'h0066,
  parameter logic [ADDR_W-1:0] IM1_VEC = 'h0038
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              nmiN,
  input  logic              intN,
  input  logic              instrEnd,
  input  logic              halted,
  input  logic              cmdEi,
  input  logic              cmdDi,
  input  logic              cmdRetn,
  input  logic              cmdSetMode,
  input  logic [1:0]        modeSel,
  input  logic [DATA_W-1:0] iReg,
  input  logic [DATA_W-1:0] ackData,
  input  logic              ackDone,
  input  logic              ackLast,
  input  logic              pushDone,
  input  logic [ADDR_W-1:0] vecWord,
  input  logic              vecDone,
  output logic              iff1,
  output logic              iff2,
  output logic [1:0]        intMode,
  output logic              busy,
  output logic              ackReq,
  output logic              pushReq,
  output logic              vecReadReq,
  output logic [ADDR_W-1:0] vecAddr,
  output logic              pcLoad,
  output logic [ADDR_W-1:0] pcTarget,
  output logic              pcHold,
  output logic              injValid,
  output logic [DATA_W-1:0] injByte
);

  dpStrobe_t strb;
  dpStatus_t stat;
  logic      boundary;
  logic      svcNmi;

  assign boundary = instrEnd || halted;
  assign injByte  = ackData;

  intc_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .boundary(boundary), .stat(stat),
    .ackDone(ackDone), .ackLast(ackLast), .pushDone(pushDone), .vecDone(vecDone),
    .strb(strb), .busy(busy), .ackReq(ackReq), .pushReq(pushReq),
    .vecReadReq(vecReadReq), .pcLoad(pcLoad), .pcHold(pcHold),
    .injValid(injValid), .svcNmi(svcNmi)
  );

  intc_dpath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NMI_VEC(NMI_VEC), .IM1_VEC(IM1_VEC)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .nmiN(nmiN), .intN(intN), .boundary(boundary),
    .cmdEi(cmdEi), .cmdDi(cmdDi), .cmdRetn(cmdRetn), .cmdSetMode(cmdSetMode),
    .modeSel(modeSel), .iReg(iReg), .ackData(ackData), .vecWord(vecWord),
    .strb(strb), .stat(stat), .iff1(iff1), .iff2(iff2), .intMode(intMode),
    .vecAddr(vecAddr), .tgt(pcTarget)
  );

endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] NMI_VEC = 'h0066
) (
  input logic              clk,
  input logic              rstN,
  input logic              instrEnd,
  input logic              halted,
  input logic              nmiPend,
  input logic              svcNmi,
  input logic              iff1,
  input logic              iff2,
  input logic [1:0]        intMode,
  input logic              busy,
  input logic              ackReq,
  input logic              pushReq,
  input logic              vecReadReq,
  input logic              pcLoad,
  input logic              pcHold,
  input logic [ADDR_W-1:0] pcTarget
);

  logic bnd;
  assign bnd = instrEnd || halted;

  p_req_onehot_r12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ackReq, pushReq, vecReadReq, pcLoad}));

  p_mode_legal_r11: assert property (@(posedge clk) disable iff (!rstN)
    intMode != 2'd3);

  p_nmi_flags_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && bnd && nmiPend) |=> (!iff1 && iff2 == $past(iff1) && pushReq));

  p_nmi_target_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pcLoad && svcNmi) |-> pcTarget == NMI_VEC);

  p_no_int_disabled_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !iff1 && !nmiPend) |=> !busy);

  p_mode0_nopush_r8: assert property (@(posedge clk) disable iff (!rstN)
    pcHold |-> (!pushReq && !pcLoad));

  p_entry_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !iff1);

endmodule

bind intc_top intc_checker #(.ADDR_W(ADDR_W), .NMI_VEC(NMI_VEC)) chk_i (
  .clk(clk), .rstN(rstN), .instrEnd(instrEnd), .halted(halted),
  .nmiPend(stat.nmiPend), .svcNmi(svcNmi), .iff1(iff1), .iff2(iff2),
  .intMode(intMode), .busy(busy), .ackReq(ackReq), .pushReq(pushReq),
  .vecReadReq(vecReadReq), .pcLoad(pcLoad), .pcHold(pcHold), .pcTarget(pcTarget)
);

// File: tb/intc_top_tb_top.sv
module intc_top_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic nmiN = 1'b1, intN = 1'b1, instrEnd = 1'b0, halted = 1'b0;
  logic cmdEi = 1'b0, cmdDi = 1'b0, cmdRetn = 1'b0, cmdSetMode = 1'b0;
  logic [1:0] modeSel = 2'd0;
  logic [7:0] iReg = 8'h00, ackData = 8'h00;
  logic ackDone = 1'b0, ackLast = 1'b0, pushDone = 1'b0, vecDone = 1'b0;
  logic [15:0] vecWord = 16'h0000;
  logic iff1, iff2, busy, ackReq, pushReq, vecReadReq, pcLoad, pcHold, injValid;
  logic [1:0] intMode;
  logic [15:0] vecAddr, pcTarget;
  logic [7:0] injByte;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  intc_top dut_i (
    .clk(clk), .rstN(rstN), .nmiN(nmiN), .intN(intN), .instrEnd(instrEnd),
    .halted(halted), .cmdEi(cmdEi), .cmdDi(cmdDi), .cmdRetn(cmdRetn),
    .cmdSetMode(cmdSetMode), .modeSel(modeSel), .iReg(iReg), .ackData(ackData),
    .ackDone(ackDone), .ackLast(ackLast), .pushDone(pushDone), .vecWord(vecWord),
    .vecDone(vecDone), .iff1(iff1), .iff2(iff2), .intMode(intMode), .busy(busy),
    .ackReq(ackReq), .pushReq(pushReq), .vecReadReq(vecReadReq), .vecAddr(vecAddr),
    .pcLoad(pcLoad), .pcTarget(pcTarget), .pcHold(pcHold), .injValid(injValid),
    .injByte(injByte)
  );

  // {mode, ackData, iReg, vecWord, expected target}
  localparam logic [49:0] VECS [4] = '{
    {2'd1, 8'hAA, 8'h00, 16'h0000, 16'h0038},
    {2'd2, 8'h34, 8'h12, 16'hBEEF, 16'hBEEF},
    {2'd2, 8'h00, 8'hFF, 16'h1234, 16'h1234},
    {2'd0, 8'hC7, 8'h00, 16'h0000, 16'h00CD}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  // arm maskable requests: set mode, enable, burn the shadow boundary
  task automatic armInt(input logic [1:0] m);
    nxt(); cmdSetMode = 1'b1; modeSel = m;
    nxt(); cmdSetMode = 1'b0; cmdEi = 1'b1;
    nxt(); cmdEi = 1'b0; instrEnd = 1'b1;
    nxt(); instrEnd = 1'b0;
  endtask

  task automatic drainMode1();
    chk("R9 ackReq", ackReq, 1'b1);
    ackDone = 1'b1; ackData = 8'h5A;
    nxt(); ackDone = 1'b0;
    chk("R9 pushReq", pushReq, 1'b1);
    pushDone = 1'b1;
    nxt(); pushDone = 1'b0;
    chk("R9 pcLoad", pcLoad, 1'b1);
    chk("R9 target", pcTarget, 16'h0038);
    nxt();
  endtask

  task automatic runVec(input logic [49:0] v);
    logic [1:0]  m;
    logic [7:0]  d, ir;
    logic [15:0] w, e;
    {m, d, ir, w, e} = v;
    armInt(m);
    intN = 1'b0; iReg = ir; instrEnd = 1'b1;
    nxt(); instrEnd = 1'b0; intN = 1'b1;
    chk("R5 busy after accept", busy, 1'b1);
    chk("R5 iff1 cleared", iff1, 1'b0);
    chk("R5 iff2 cleared", iff2, 1'b0);
    if (m == 2'd2) begin
      chk("R10 push first", {pushReq, ackReq}, 2'b10);
      pushDone = 1'b1;
      nxt(); pushDone = 1'b0;
      chk("R10 ackReq", ackReq, 1'b1);
      ackData = d; ackDone = 1'b1;
      nxt(); ackDone = 1'b0;
      chk("R10 vecReadReq", vecReadReq, 1'b1);
      chk("R10 vecAddr", vecAddr, {ir, d});
      vecWord = w; vecDone = 1'b1;
      nxt(); vecDone = 1'b0;
      chk("R10 pcLoad", pcLoad, 1'b1);
      chk("R10 target", pcTarget, e);
      nxt();
    end else if (m == 2'd1) begin
      chk("R9 ack first", {pushReq, ackReq}, 2'b01);
      ackData = d; ackDone = 1'b1;
      nxt(); ackDone = 1'b0;
      chk("R9 pushReq", pushReq, 1'b1);
      pushDone = 1'b1;
      nxt(); pushDone = 1'b0;
      chk("R9 pcLoad", pcLoad, 1'b1);
      chk("R9 target ignores data", pcTarget, e);
      nxt();
    end else begin
      chk("R8 ackReq/pcHold", {ackReq, pcHold, pushReq}, 3'b110);
      ackData = d; ackDone = 1'b1; ackLast = 1'b0;
      #1 chk("R8 first byte", {injValid, injByte}, {1'b1, d});
      nxt(); ackData = e[7:0]; ackLast = 1'b1;
      chk("R8 still acking", {ackReq, pushReq, pcLoad}, 3'b100);
      #1 chk("R8 second byte", {injValid, injByte}, {1'b1, e[7:0]});
      nxt(); ackDone = 1'b0; ackLast = 1'b0;
    end
    chk("R12 back to idle", {busy, ackReq, pushReq, vecReadReq, pcLoad}, 5'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) nxt();
    chk("R1 reset held", {iff1, iff2, intMode, busy, pcTarget}, 21'd0);
    rstN = 1'b1;
    nxt();
    chk("R1 after release", {iff1, iff2, intMode, pcTarget}, 20'd0);
    chk("R1 requests low", {busy, ackReq, pushReq, vecReadReq, pcLoad, injValid}, 6'd0);

    foreach (VECS[i]) runVec(VECS[i]);

    // R11: mode load and illegal value
    cmdSetMode = 1'b1; modeSel = 2'd1;
    nxt(); modeSel = 2'd3;
    nxt(); cmdSetMode = 1'b0;
    chk("R11 mode 3 ignored", intMode, 2'd1);
    cmdEi = 1'b1;
    nxt(); cmdEi = 1'b0; cmdDi = 1'b1;
    nxt(); cmdDi = 1'b0;
    chk("R11 di clears", {iff1, iff2}, 2'b00);

    // R5: disabled INT ignored
    intN = 1'b0; instrEnd = 1'b1;
    nxt(); instrEnd = 1'b0;
    chk("R5 ignored while disabled", busy, 1'b0);

    // R7: enable shadow
    cmdEi = 1'b1;
    nxt(); cmdEi = 1'b0; instrEnd = 1'b1;
    nxt(); instrEnd = 1'b0;
    chk("R7 shadow blocks", {busy, iff1, iff2}, 3'b011);
    instrEnd = 1'b1;
    nxt(); instrEnd = 1'b0; intN = 1'b1;
    chk("R7 accepted after shadow", {busy, ackReq}, 2'b11);
    drainMode1();

    // R2/R3: NMI latched, halted boundary
    cmdEi = 1'b1;
    nxt(); cmdEi = 1'b0; instrEnd = 1'b1;
    nxt(); instrEnd = 1'b0; nmiN = 1'b0;
    nxt(); nmiN = 1'b1;
    nxt(); nxt();
    chk("R2 no boundary stays idle", busy, 1'b0);
    halted = 1'b1;
    nxt(); halted = 1'b0;
    chk("R2 halted boundary", busy, 1'b1);
    chk("R3 iff copy", {iff1, iff2, pushReq}, 3'b011);
    pushDone = 1'b1;
    nxt(); pushDone = 1'b0;
    chk("R3 target", {pcLoad, pcTarget}, {1'b1, 16'h0066});
    nxt();
    cmdRetn = 1'b1;
    nxt(); cmdRetn = 1'b0;
    chk("R4 restore", iff1, 1'b1);

    // R6: NMI beats INT
    nmiN = 1'b0;
    nxt(); intN = 1'b0; instrEnd = 1'b1;
    nxt(); instrEnd = 1'b0; intN = 1'b1; nmiN = 1'b1;
    chk("R6 nmi wins", {pushReq, ackReq}, 2'b10);
    pushDone = 1'b1;
    nxt(); pushDone = 1'b0;
    chk("R6 nmi target", {pcLoad, pcTarget}, {1'b1, 16'h0066});
    nxt();
    chk("R3 saved enable", {iff1, iff2, busy}, 3'b010);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule